// File: doc/BRIEF.md
# Shared EEPROM and PHY Access Engine

This block lets a host processor read or write one 16-bit word at a time in either a serial configuration EEPROM (three-wire Microwire style) or a management register of an Ethernet PHY (MDIO style). Both targets share four byte-wide host registers. A target bit in the control register picks the device. Two command bits, one for read and one for write, start the access. A 6-bit field gives the EEPROM word address or the PHY register number. The word itself passes through a pair of data byte registers.

Software sets up the address and, for a write, the data bytes. It then raises a command bit and polls the busy flag until the flag drops. The engine never clears the command bits, so software must clear a bit before it can start the next access. Only the low two bits of the 5-bit PHY address can be programmed. The top three bits are always sent as zero. Both serial clocks run at the system clock divided by `2*HALF_DIV`.

Top module: `cfg_mgmt_port`

## Requirements
- R1: After reset, the control register reads 0x00, the address register reads 0x40 (PHY address low bits = 01, field = 0), and both data byte registers read 0x00.
- R2: Register select codes are 0 = control, 1 = address, 2 = data low (word bits 7:0), 3 = data high (word bits 15:8). Control bits are: bit 0 read command, bit 1 write command, bit 2 target (0 EEPROM, 1 PHY), bit 7 busy (read-only). In the address register, bits 7:6 are the PHY address low bits and bits 5:0 are the word or register address.
- R3: An access starts only on a 0-to-1 change of a command bit while the engine is idle. Busy reads 1 in the second clock after the host write. A command bit that stays set does not start another access.
- R4: When the read and write command bits are both set, no access starts: busy stays 0 and neither serial clock toggles.
- R5: The engine never clears the command bits. They keep their written value after the access completes.
- R6: A PHY read sends 32 ones, 01, opcode 10, the PHY address and the register address, each MSB first, with `mdio_oe` high. It releases the line (`mdio_oe` low) for the 2 turnaround bits and the 16 data bits. It samples `mdio_i` on the rising `mdc` edge of each data bit, MSB first.
- R7: A PHY write sends 32 ones, 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 data bits MSB first, with `mdio_oe` high for all 64 bits.
- R8: An EEPROM read holds `ee_cs` high for 25 `ee_sk` cycles. On `ee_di` it sends start bit 1, opcode 10 and the 6-bit address, MSB first. It then samples 16 data bits, MSB first, from `ee_do` on the rising `ee_sk` edges.
- R9: An EEPROM write sends start bit 1, opcode 01, the 6-bit address and the 16 data bits, MSB first, on `ee_di` over 25 `ee_sk` cycles.
- R10: Each serial clock period lasts 2*HALF_DIV system clocks, with HALF_DIV cycles high. Only the selected port's clock toggles.
- R11: On a read, the data byte registers take the received word in the same cycle that busy falls. A write leaves the data registers holding the written word.
- R12: The PHY address sent is {000, address bits 7:6}. The PHY register number is address bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read-back of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for the management data pad |
| mdio_i | input | 1 | Management data from the pad |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with HALF_DIV = 2, so a full 64-bit management frame takes only 256 system clocks. At that length, each access can be captured in full by behavioural device models that answer on the rising serial clock edges. The small divider also keeps the count of clock-high cycles per frame exact and easy to compare, which brings R10 within reach. Every table entry can run a whole PHY or EEPROM frame, and the idle-hold and both-bits-set cases can be watched over many serial periods.

// File: rtl/cfg_mgmt_pkg.sv
package cfg_mgmt_pkg;

    localparam int FRAME_W = 64;
    localparam int WORD_W  = 16;
    localparam int IDX_W   = 7;

    typedef enum logic { TGT_EEPROM = 1'b0, TGT_PHY = 1'b1 } target_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DLO  = 2'd2,
        SEL_DHI  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        target_e tgt;
        logic    wr;
        logic    rd;
    } cmd_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [IDX_W-1:0]   len;
        logic [IDX_W-1:0]   rx_from;
        logic [IDX_W-1:0]   drive_until;
    } frame_t;

    function automatic logic [1:0] op_code(logic is_rd);
        return is_rd ? 2'b10 : 2'b01;
    endfunction

    function automatic frame_t build_frame(target_e tgt, logic is_rd, logic [1:0] phy_lo,
                                           logic [5:0] radr, logic [WORD_W-1:0] wdata);
        frame_t f;
        logic [WORD_W-1:0] dat;
        dat = is_rd ? '0 : wdata;
        if (tgt == TGT_PHY) begin
            f.bits        = {32'hFFFF_FFFF, 2'b01, op_code(is_rd), 3'b000, phy_lo,
                             radr[4:0], (is_rd ? 2'b00 : 2'b10), dat};
            f.len         = 7'd64;
            f.rx_from     = 7'd48;
            f.drive_until = is_rd ? 7'd46 : 7'd64;
        end else begin
            f.bits        = {1'b1, op_code(is_rd), radr, dat, 39'd0};
            f.len         = 7'd25;
            f.rx_from     = 7'd9;
            f.drive_until = is_rd ? 7'd9 : 7'd25;
        end
        return f;
    endfunction

endpackage

// File: rtl/cfg_mgmt_regs.sv
module cfg_mgmt_regs
    import cfg_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [7:0]        host_wdata,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              busy,
    output logic [7:0]        host_rdata,
    output cmd_t              cmd,
    output logic [7:0]        addr,
    output logic [WORD_W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '{tgt: TGT_EEPROM, wr: 1'b0, rd: 1'b0};
            addr <= 8'h40;
            word <= '0;
        end else begin
            if (host_we) begin
                case (reg_sel_e'(host_sel))
                    SEL_CTRL: cmd       <= cmd_t'(host_wdata[2:0]);
                    SEL_ADDR: addr      <= host_wdata;
                    SEL_DLO:  word[7:0] <= host_wdata;
                    SEL_DHI:  word[15:8] <= host_wdata;
                    default: ;
                endcase
            end
            if (ld_en) word <= ld_word;
        end
    end

    always_comb begin
        case (reg_sel_e'(host_sel))
            SEL_CTRL: host_rdata = {busy, 4'b0000, cmd};
            SEL_ADDR: host_rdata = addr;
            SEL_DLO:  host_rdata = word[7:0];
            default:  host_rdata = word[15:8];
        endcase
    end

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmd.rd) || $fell(cmd.wr)) |-> $past(host_we && host_sel == SEL_CTRL));

endmodule

// File: rtl/cfg_mgmt_shifter.sv
module cfg_mgmt_shifter
    import cfg_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_t            frame,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_en,
    output logic              active,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0]   div_q;
    logic [IDX_W-1:0]   idx_q, len_q, rxf_q, drv_q;
    logic [FRAME_W-1:0] sh_q;
    logic               sclk_q, act_q, done_q;
    logic [WORD_W-1:0]  rx_q;
    logic               half_end;

    assign half_end = (div_q == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            rxf_q  <= '0;
            drv_q  <= '0;
            sh_q   <= '0;
            sclk_q <= 1'b0;
            act_q  <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !act_q) begin
                act_q  <= 1'b1;
                sh_q   <= frame.bits;
                len_q  <= frame.len;
                rxf_q  <= frame.rx_from;
                drv_q  <= frame.drive_until;
                idx_q  <= '0;
                div_q  <= '0;
                sclk_q <= 1'b0;
                rx_q   <= '0;
            end else if (act_q) begin
                if (half_end) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        if (idx_q >= rxf_q) rx_q <= {rx_q[WORD_W-2:0], sdi};
                    end else begin
                        sclk_q <= 1'b0;
                        if (idx_q == len_q - 7'd1) begin
                            act_q  <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 7'd1;
                            sh_q  <= sh_q << 1;
                        end
                    end
                end else begin
                    div_q <= div_q + DIV_W'(1);
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign sdo     = sh_q[FRAME_W-1];
    assign sdo_en  = act_q && (idx_q < drv_q);
    assign active  = act_q;
    assign done    = done_q;
    assign rx_word = rx_q;

    // R10
    clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> !sclk_q);

    // R10
    done_low_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !act_q && !sclk_q);

endmodule

// File: rtl/cfg_mgmt_port.sv
module cfg_mgmt_port
    import cfg_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_we,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       mdio_i,
    output logic       ee_cs,
    output logic       ee_sk,
    output logic       ee_di,
    input  logic       ee_do
);

    cmd_t              cmd;
    logic [7:0]        addr;
    logic [WORD_W-1:0] word, rx_word;
    logic              busy_q, rd_prev, wr_prev, is_rd_q;
    target_e           tgt_q;
    logic              rd_rise, wr_rise, start;
    logic              sclk, sdo, sdo_en, eng_act, eng_done, sdi;
    frame_t            frame;

    cfg_mgmt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .ld_en      (eng_done && is_rd_q),
        .ld_word    (rx_word),
        .busy       (busy_q),
        .host_rdata (host_rdata),
        .cmd        (cmd),
        .addr       (addr),
        .word       (word)
    );

    assign rd_rise = cmd.rd && !rd_prev;
    assign wr_rise = cmd.wr && !wr_prev;
    assign start   = !busy_q && (rd_rise || wr_rise) && !(cmd.rd && cmd.wr);
    assign frame   = build_frame(cmd.tgt, cmd.rd, addr[7:6], addr[5:0], word);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
            is_rd_q <= 1'b0;
            tgt_q   <= TGT_EEPROM;
        end else begin
            rd_prev <= cmd.rd;
            wr_prev <= cmd.wr;
            if (start) begin
                busy_q  <= 1'b1;
                is_rd_q <= cmd.rd;
                tgt_q   <= cmd.tgt;
            end else if (eng_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign sdi = (tgt_q == TGT_PHY) ? mdio_i : ee_do;

    cfg_mgmt_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .frame   (frame),
        .sdi     (sdi),
        .sclk    (sclk),
        .sdo     (sdo),
        .sdo_en  (sdo_en),
        .active  (eng_act),
        .done    (eng_done),
        .rx_word (rx_word)
    );

    assign mdc     = sclk && (tgt_q == TGT_PHY);
    assign mdio_o  = sdo;
    assign mdio_oe = sdo_en && (tgt_q == TGT_PHY);
    assign ee_cs   = eng_act && (tgt_q == TGT_EEPROM);
    assign ee_sk   = sclk && (tgt_q == TGT_EEPROM);
    assign ee_di   = sdo && sdo_en && (tgt_q == TGT_EEPROM);

    // R4
    both_cmd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd && cmd.wr && !busy_q) |=> !busy_q);

    // R3
    start_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past((cmd.rd && !rd_prev) || (cmd.wr && !wr_prev)));

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(eng_done));

    // R6
    mdio_drive_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy_q && !ee_cs);

    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ee_sk && mdc));

endmodule

// File: tb/cfg_mgmt_port_test.sv
module cfg_mgmt_port_test;

    localparam int HALF_DIV = 2;
    localparam int NVEC     = 6;

    // {target, is_read, addr, wdata, device word}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 8'h45, 16'h0000, 16'hBEEF},
        {1'b1, 1'b0, 8'hA3, 16'h1234, 16'h0000},
        {1'b1, 1'b1, 8'hFF, 16'h0000, 16'h8001},
        {1'b0, 1'b1, 8'h2A, 16'h0000, 16'hC35A},
        {1'b0, 1'b0, 8'h3F, 16'hA5F0, 16'h0000},
        {1'b0, 1'b1, 8'h00, 16'h0000, 16'h0001}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       mdc, mdio_o, mdio_oe, ee_cs, ee_sk, ee_di;
    logic       mdio_i = 1'b1;
    logic       ee_do  = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic        model_clr = 1'b0;
    logic [15:0] phy_word = 16'h0;
    logic [15:0] ee_word  = 16'h0;
    logic [63:0] m_cap, m_oe, e_cap;
    int          m_cnt, e_cnt, m_hi;

    always #5 clk = ~clk;

    cfg_mgmt_port #(.HALF_DIV(HALF_DIV)) uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // PHY model: capture on rising mdc, answer after the edge
    always @(posedge mdc or posedge model_clr) begin
        if (model_clr) begin
            m_cnt <= 0; m_cap <= '0; m_oe <= '0; mdio_i <= 1'b1;
        end else begin
            m_cap <= {m_cap[62:0], mdio_o};
            m_oe  <= {m_oe[62:0], mdio_oe};
            m_cnt <= m_cnt + 1;
            if (m_cnt + 1 >= 48 && m_cnt + 1 < 64) mdio_i <= phy_word[63 - (m_cnt + 1)];
            else mdio_i <= 1'b1;
        end
    end

    // EEPROM model
    always @(posedge ee_sk or posedge model_clr) begin
        if (model_clr) begin
            e_cnt <= 0; e_cap <= '0; ee_do <= 1'b0;
        end else if (ee_cs) begin
            e_cap <= {e_cap[62:0], ee_di};
            e_cnt <= e_cnt + 1;
            if (e_cnt + 1 >= 9 && e_cnt + 1 < 25) ee_do <= ee_word[24 - (e_cnt + 1)];
            else ee_do <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (model_clr) m_hi <= 0;
        else if (mdc) m_hi <= m_hi + 1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic clear_models();
        @(negedge clk);
        model_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_clr = 1'b0;
    endtask

    task automatic run_vec(input logic [41:0] v);
        logic        tgt, isrd;
        logic [7:0]  a, r, dlo, dhi;
        logic [15:0] wd, dw;
        logic [63:0] exp, exp_oe;
        int          guard;
        {tgt, isrd, a, wd, dw} = v;
        phy_word = dw;
        ee_word  = dw;
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, a);
        wr_reg(2'd2, wd[7:0]);
        wr_reg(2'd3, wd[15:8]);
        clear_models();
        wr_reg(2'd0, {5'b0, tgt, !isrd, isrd});
        @(posedge clk); @(negedge clk);
        rd_reg(2'd0, r);
        check(r[7] == 1'b1, "R3 busy after command edge", 64'(r[7]), 64'd1);
        guard = 0;
        dlo = 8'h00; dhi = 8'h00;
        do begin
            @(negedge clk);
            rd_reg(2'd0, r);
            guard++;
            if (r[7] == 1'b0) begin
                rd_reg(2'd2, dlo);
                rd_reg(2'd3, dhi);
            end
        end while (r[7] && guard < 3000);
        check(r[2:0] == {tgt, !isrd, isrd}, "R5 command bits kept", 64'(r[2:0]), 64'({tgt, !isrd, isrd}));
        if (tgt) begin
            exp = {32'hFFFF_FFFF, 2'b01, (isrd ? 2'b10 : 2'b01), 3'b000, a[7:6], a[4:0],
                   (isrd ? 2'b00 : 2'b10), (isrd ? 16'h0 : wd)};
            exp_oe = isrd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
            check(m_oe == exp_oe, isrd ? "R6 drive enable" : "R7 drive enable", m_oe, exp_oe);
            check((m_cap & m_oe) == (exp & exp_oe), isrd ? "R6/R12 read frame" : "R7/R12 write frame",
                  m_cap & m_oe, exp & exp_oe);
            check(m_cnt == 64, "R10 mdc edges", 64'(m_cnt), 64'd64);
            check(m_hi == 64 * HALF_DIV, "R10 mdc high cycles", 64'(m_hi), 64'(64 * HALF_DIV));
            check(e_cnt == 0, "R10 eeprom clock idle", 64'(e_cnt), 64'd0);
        end else begin
            exp = 64'({1'b1, (isrd ? 2'b10 : 2'b01), a[5:0], (isrd ? 16'h0 : wd)});
            check(e_cap[24:0] == exp[24:0], isrd ? "R8 read frame" : "R9 write frame",
                  64'(e_cap[24:0]), exp);
            check(e_cnt == 25, "R8 ee_sk edges", 64'(e_cnt), 64'd25);
            check(m_cnt == 0, "R10 mdc idle", 64'(m_cnt), 64'd0);
        end
        exp = isrd ? 64'(dw) : 64'(wd);
        check({dhi, dlo} == exp[15:0], "R11 data at busy fall", 64'({dhi, dlo}), exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int         e0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_models();

        // R1 reset values, R2 layout
        rd_reg(2'd0, r); check(r == 8'h00, "R1 ctrl reset", 64'(r), 64'h00);
        rd_reg(2'd1, r); check(r == 8'h40, "R1 addr reset", 64'(r), 64'h40);
        rd_reg(2'd2, r); check(r == 8'h00, "R1 data low reset", 64'(r), 64'h00);
        rd_reg(2'd3, r); check(r == 8'h00, "R1 data high reset", 64'(r), 64'h00);
        wr_reg(2'd1, 8'h9C);
        rd_reg(2'd1, r); check(r == 8'h9C, "R2 addr readback", 64'(r), 64'h9C);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R3: held read command does not restart
        e0 = e_cnt;
        repeat (40) @(negedge clk);
        rd_reg(2'd0, r);
        check(r[7] == 1'b0, "R3 held command idle", 64'(r[7]), 64'd0);
        check(e_cnt == e0, "R3 no new frame", 64'(e_cnt), 64'(e0));

        // R4: both command bits set at once
        wr_reg(2'd0, 8'h00);
        clear_models();
        wr_reg(2'd0, 8'h07);
        repeat (40) @(negedge clk);
        rd_reg(2'd0, r);
        check(r[7] == 1'b0, "R4 both bits busy", 64'(r[7]), 64'd0);
        check(r[2:0] == 3'b111, "R4 both bits kept", 64'(r[2:0]), 64'h7);
        check(m_cnt == 0 && e_cnt == 0, "R4 clocks idle", 64'(m_cnt + e_cnt), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule